// File: doc/BRIEF.md
# Cache Victim Way Selector

This block chooses which way of a highly associative cache receives the next line fill. The fill engine presents a request on a valid/ready channel. The selector answers with a way index on a second valid/ready channel. That index comes from one of two sources, picked at run time by a control pin: a sequential counter or a free-running pseudorandom generator.

A programmable lock floor supports lockdown. Ways numbered below the floor are never handed out, so their contents stay resident. Raising the floor shrinks the replaceable part of the cache. A flush pulse puts the sequential counter back at the floor, which is the expected step after the cache has been cleaned or invalidated.

Back-pressure works as follows. The request channel accepts a request only while flush is low and the output slot is free or draining in the same cycle. The output holds its index stable until the consumer takes it.

Top module: `victim_way_sel`

## Requirements
- R1: After reset `victim_valid` is 0, `fill_req_ready` is 1, and the first sequential-mode victim equals `lock_base`.
- R2: In sequential mode (`use_random`=0) each accepted request returns the next way, one above the previous one. Idle cycles leave the counter unchanged.
- R3: In sequential mode, a request served with way 63 leaves the counter at the current `lock_base`, so the next victim is the floor rather than 0.
- R4: No accepted request returns a way below the `lock_base` that was present on the accepting edge.
- R5: If `lock_base` is raised above the counter, the next sequential victim is `lock_base`.
- R6: While `flush` is 1, `fill_req_ready` is 0. After a flush the next sequential victim is `lock_base`.
- R7: The generator is a 6-bit Fibonacci shift register. Reset loads 1. On every clock after reset it shifts left and takes in bit5 XOR bit4. In random mode (`use_random`=1) the victim is the generator value G on the accepting edge when G is not below the floor B. Otherwise the victim is B + (G mod (64 − B)).
- R8: With `lock_base`=63, every request returns way 63 in both modes.
- R9: `fill_req_ready` = !flush && (!victim_valid || victim_ready). While `victim_valid` is 1 and `victim_ready` is 0, `victim_way` holds its value.
- R10: Requests served in random mode do not move the sequential counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Returns the sequential counter to the floor |
| use_random | input | 1 | 0 = sequential, 1 = pseudorandom |
| lock_base | input | 6 | Lowest way that may be replaced |
| fill_req_valid | input | 1 | Fill request present |
| fill_req_ready | output | 1 | Request accepted this cycle when valid |
| victim_valid | output | 1 | Victim index available |
| victim_ready | input | 1 | Consumer takes the index |
| victim_way | output | 6 | Selected way |

## Verification
Sequential runs start from floor 0 with idle gaps between requests, which shows that the counter advances only on accepted requests. Runs with floors of 60 and 10 separate a wrap back to the floor from a wrap to zero. They also show the jump to a newly raised floor. Random runs with floor 0 and floor 10 compare every index with a generator model stepped in lockstep, which shows whether low values are folded into the unlocked range. Back-pressure and floor 63 cover stalls, holding of the output and the single-way case.

// File: rtl/vws_pkg.sv
package vws_pkg;
  typedef enum logic {POL_SEQ = 1'b0, POL_RAND = 1'b1} policy_e;

  function automatic logic [5:0] lfsr6_step(input logic [5:0] s, input logic [5:0] taps);
    return {s[4:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/vws_seq_counter.sv
module vws_seq_counter #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             adv,
  input  logic [IDX_W-1:0] floor_idx,
  output logic [IDX_W-1:0] cur_way
);
  localparam logic [IDX_W-1:0] TOP_WAY = '1;

  logic [IDX_W-1:0] ctr_q;

  assign cur_way = (ctr_q < floor_idx) ? floor_idx : ctr_q;

  always_ff @(posedge clk) begin
    if (rst || flush)
      ctr_q <= floor_idx;
    else if (adv)
      ctr_q <= (cur_way == TOP_WAY) ? floor_idx : cur_way + 1'b1;
  end

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !flush) |=> $stable(ctr_q)); // R2

  AST_WRAP_TO_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (adv && !flush && cur_way == TOP_WAY) |=> (cur_way == $past(floor_idx)) || (floor_idx != $past(floor_idx))); // R3
endmodule

// File: rtl/vws_lfsr.sv
module vws_lfsr #(
  parameter int              IDX_W = 6,
  parameter logic [IDX_W-1:0] TAPS = 6'b110000,
  parameter logic [IDX_W-1:0] SEED = 6'd1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] state
);
  import vws_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= lfsr6_step(state, TAPS);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    state != '0); // R7
endmodule

// File: rtl/vws_rand_map.sv
module vws_rand_map #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] rnd,
  input  logic [IDX_W-1:0] floor_idx,
  output logic [IDX_W-1:0] way
);
  localparam int WAYS = 1 << IDX_W;

  logic [IDX_W:0] span;
  logic [IDX_W:0] fold;

  always_comb begin
    span = (IDX_W+1)'(WAYS) - {1'b0, floor_idx};
    fold = {1'b0, rnd} % span;
    if (rnd < floor_idx) way = floor_idx + fold[IDX_W-1:0];
    else                 way = rnd;
  end
endmodule

// File: rtl/victim_way_sel.sv
module victim_way_sel #(
  parameter int               IDX_W = 6,
  parameter logic [IDX_W-1:0] LFSR_TAPS = 6'b110000,
  parameter logic [IDX_W-1:0] LFSR_SEED = 6'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             use_random,
  input  logic [IDX_W-1:0] lock_base,
  input  logic             fill_req_valid,
  output logic             fill_req_ready,
  output logic             victim_valid,
  input  logic             victim_ready,
  output logic [IDX_W-1:0] victim_way
);
  import vws_pkg::*;

  localparam logic [IDX_W-1:0] TOP_WAY = '1;

  policy_e          pol;
  logic             accept;
  logic [IDX_W-1:0] seq_way, rnd_state, rnd_way;
  logic             vld_q;
  logic [IDX_W-1:0] way_q;

  assign pol            = policy_e'(use_random);
  assign fill_req_ready = !flush && (!vld_q || victim_ready);
  assign accept         = fill_req_valid && fill_req_ready;

  vws_seq_counter #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .flush(flush),
    .adv(accept && pol == POL_SEQ),
    .floor_idx(lock_base), .cur_way(seq_way)
  );

  vws_lfsr #(.IDX_W(IDX_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .state(rnd_state)
  );

  vws_rand_map #(.IDX_W(IDX_W)) u_map (
    .rnd(rnd_state), .floor_idx(lock_base), .way(rnd_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      way_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      way_q <= (pol == POL_RAND) ? rnd_way : seq_way;
    end else if (victim_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign victim_valid = vld_q;
  assign victim_way   = way_q;

  AST_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (rst)
    accept |=> victim_way >= $past(lock_base)); // R4

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (victim_valid && !victim_ready) |=> (victim_valid && $stable(victim_way))); // R9

  AST_FLUSH_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (flush && !victim_valid) |=> !victim_valid); // R6

  AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (rst)
    (accept && lock_base == TOP_WAY) |=> victim_way == TOP_WAY); // R8
endmodule

// File: tb/victim_way_sel_tb.sv
module victim_way_sel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic       use_random = 1'b0;
  logic [5:0] lock_base = 6'd0;
  logic       fill_req_valid = 1'b0;
  logic       fill_req_ready;
  logic       victim_valid;
  logic       victim_ready = 1'b1;
  logic [5:0] victim_way;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];
  int    tb_ctr;
  logic [5:0] tb_lfsr;

  always #4 clk = ~clk;

  victim_way_sel u_dut (
    .clk(clk), .rst(rst), .flush(flush), .use_random(use_random),
    .lock_base(lock_base), .fill_req_valid(fill_req_valid),
    .fill_req_ready(fill_req_ready), .victim_valid(victim_valid),
    .victim_ready(victim_ready), .victim_way(victim_way)
  );

  // generator model from R7
  always @(posedge clk) begin
    if (rst) tb_lfsr <= 6'd1;
    else     tb_lfsr <= {tb_lfsr[4:0], tb_lfsr[5] ^ tb_lfsr[4]};
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int expected_way();
    int b = lock_base;
    int e;
    if (use_random) begin
      if (int'(tb_lfsr) >= b) return tb_lfsr;
      return b + (int'(tb_lfsr) % (64 - b));
    end
    e = (tb_ctr < b) ? b : tb_ctr;
    tb_ctr = (e == 63) ? b : e + 1;
    return e;
  endfunction

  // driver: called at a negedge
  task automatic send(input string tag);
    fill_req_valid = 1'b1;
    #1;
    while (!fill_req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(expected_way());
    tag_q.push_back(tag);
    @(negedge clk);
    fill_req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (!rst && victim_valid && victim_ready) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 unexpected output actual=%0d expected=none", victim_way);
        end else begin
          check(tag_q.pop_front(), victim_way, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int held;
    tb_ctr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset victim_valid", victim_valid, 0);
    check("R1 reset ready", fill_req_ready, 1);
    @(negedge clk);

    for (int i = 0; i < 5; i++) send("R1 R2 sequential step");
    idle(3);
    send("R2 hold across idle");

    lock_base = 6'd60;
    send("R5 jump to raised floor");
    for (int i = 0; i < 4; i++) send("R3 wrap to floor 60");

    flush = 1'b1;
    #1;
    check("R6 ready low in flush", fill_req_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    tb_ctr = lock_base;
    send("R6 after flush");

    lock_base = 6'd10;
    for (int i = 0; i < 4; i++) send("R3 wrap to floor 10");

    use_random = 1'b1;
    for (int i = 0; i < 20; i++) send("R7 R4 random floor 10");
    use_random = 1'b0;
    send("R10 counter kept through random");

    lock_base = 6'd0;
    use_random = 1'b1;
    for (int i = 0; i < 10; i++) send("R7 random floor 0");

    lock_base = 6'd63;
    for (int i = 0; i < 3; i++) send("R8 random single way");
    use_random = 1'b0;
    for (int i = 0; i < 3; i++) send("R8 sequential single way");

    lock_base = 6'd0;
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    tb_ctr = 0;
    idle(2);
    victim_ready = 1'b0;
    send("R9 first under stall");
    fill_req_valid = 1'b1;
    #1;
    check("R9 ready low while output held", fill_req_ready, 0);
    held = victim_way;
    repeat (3) @(negedge clk);
    #1;
    check("R9 output stable while stalled", victim_way, held);
    check("R9 valid kept while stalled", victim_valid, 1);
    fill_req_valid = 1'b0;
    victim_ready = 1'b1;
    send("R9 second after release");

    idle(4);
    check("R9 all outputs drained", exp_q.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule